// File: doc/BRIEF.md
# Reconfigurable N-Modular Redundancy Controller

This block sits behind a group of replicated computing modules that all produce the same W-bit result each cycle. A fixed number of them, N (odd), are active and vote. The remaining M are spares and wait in reserve. The block forms the bitwise majority of the active words and drives it out as the protected result. In the same cycle it compares each active word with that majority.

An active module whose word differs from the majority is dropped at the next clock edge. The lowest-numbered unused spare takes over its voting slot. Once the spares are used up, the block keeps voting and masking faults, but it can no longer swap modules. A later disagreement then raises a sticky alarm. When more than (N-1)/2 active words differ from the majority at once, the vote can no longer be trusted. The block flags this case and leaves the active set unchanged.

The integrator gives module i's word on bits [i*W +: W] of `mod_words`. Modules 0..N-1 form the initial active set and modules N..N+M-1 are the spares.

Top module: `nmr_reconfig_ctrl`

## Requirements
- R1: Each bit of `voted` is 1 exactly when more than N/2 of the active modules' words have that bit set. For N=3 this is AB+BC+AC over the three active words.
- R2: `voted` and `uncorrectable` are combinational from the current inputs. In the cycle a disagreement is seen, `voted` already carries the majority value and `active_mask` still shows the old set.
- R3: While `rst_n` is low at a rising clock edge, the block resets synchronously. After reset, `active_mask` has bits 0..N-1 set, `spares_left` equals M, `retired` is all zero and `no_spare_alarm` is 0.
- R4: An active module whose word differs from `voted` (with `uncorrectable` low and a spare left) is replaced at the next rising edge. The lowest-numbered unused spare takes its voting slot, so spares are consumed in ascending index order. The replaced module's bit in `retired` is set.
- R5: `uncorrectable` is high whenever more than (N-1)/2 active words differ from `voted`. While it is high, no module is replaced at the following edge.
- R6: If any active word differs from `voted` while `spares_left` is 0, then at the next edge `no_spare_alarm` rises and stays high until reset. The active set stays the same and voting continues.
- R7: A retired module never rejoins the active set. Its input word has no effect on `voted` or on any later reconfiguration.
- R8: `spares_left` decreases by exactly one for each replacement, so `spares_left` plus the number of set `retired` bits always equals M.
- R9: The words of spares that are not yet active have no effect on `voted`, `uncorrectable` or the active set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_words | input | (N+M)*W | Module i's output word at bits [i*W +: W] |
| voted | output | W | Bitwise majority of the active words |
| active_mask | output | N+M | Bit i set when module i currently votes |
| spares_left | output | clog2(M+1) | Number of spares not yet brought in |
| retired | output | N+M | Bit i set once module i has been removed |
| no_spare_alarm | output | 1 | Sticky: a disagreement occurred with no spare left |
| uncorrectable | output | 1 | Too many active words disagree to trust the vote |

## Verification
The assertions assume three things. First, `mod_words` is fully driven at every clock edge after reset. Second, N is odd. Third, M is at least one, so the spare counter and slot table have non-zero width. The bench drives every module word from time zero and changes inputs only on the falling clock edge. It uses the default N=3, M=2 configuration, so the slot table always holds distinct module indices. The check that exactly N modules are active then relies only on the block's own replacement order.

// File: rtl/nmr_pkg.sv
// Package nmr_pkg
// Shared helpers for the redundancy controller. Assumes no configuration
// uses more than MAX_SLOTS voting slots.
package nmr_pkg;
    localparam int unsigned MAX_SLOTS = 32;

    // Number of set bits in a zero-extended slot vector.
    function automatic int unsigned count_set(input logic [MAX_SLOTS-1:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < MAX_SLOTS; i++) begin
            n = n + int'(v[i]);
        end
        return n;
    endfunction
endpackage

// File: rtl/nmr_voter.sv
// Module nmr_voter
// Bitwise majority over N slot words. Uses the two-level AND-OR form for
// N=3 and a population count for any other odd N. Purely combinational.
module nmr_voter
    import nmr_pkg::*;
#(
    parameter int unsigned N = 3,
    parameter int unsigned W = 8
) (
    input  logic [N*W-1:0] slot_words,
    output logic [W-1:0]   voted
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [N-1:0] column;
        // Gather bit b of every slot word.
        for (genvar s = 0; s < N; s++) begin : g_col
            assign column[s] = slot_words[s*W + b];
        end
        if (N == 3) begin : g_tmr
            // Three-input majority gate.
            assign voted[b] = (column[0] & column[1]) | (column[1] & column[2])
                            | (column[0] & column[2]);
        end else begin : g_cnt
            // Majority by counting ones.
            assign voted[b] = (count_set(MAX_SLOTS'(column)) > (N / 2));
        end
    end
endmodule

// File: rtl/nmr_disagree.sv
// Module nmr_disagree
// Compares every active slot word with the voted word. Raises the
// uncorrectable flag when more than (N-1)/2 slots disagree. Combinational.
module nmr_disagree
    import nmr_pkg::*;
#(
    parameter int unsigned N = 3,
    parameter int unsigned W = 8
) (
    input  logic [N*W-1:0] slot_words,
    input  logic [W-1:0]   voted,
    output logic [N-1:0]   disagree,
    output logic           uncorrectable
);
    // One word comparator per slot.
    for (genvar s = 0; s < N; s++) begin : g_cmp
        assign disagree[s] = (slot_words[s*W +: W] != voted);
    end

    // Too many dissenters: the majority itself is suspect.
    assign uncorrectable = (count_set(MAX_SLOTS'(disagree)) > ((N - 1) / 2));
endmodule

// File: rtl/nmr_switch.sv
// Module nmr_switch
// Holds the slot-to-module table, the spare counter, the retired flags and
// the sticky no-spare alarm. Walks the slots from lowest to highest and hands
// each dissenting slot the next spare. Assumes M >= 1 and distinct start
// indices.
module nmr_switch #(
    parameter int unsigned N  = 3,
    parameter int unsigned M  = 2,
    parameter int unsigned IW = 3,
    parameter int unsigned SW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      disagree,
    input  logic              uncorrectable,
    output logic [N*IW-1:0]   slot_map,
    output logic [SW-1:0]     spares_left,
    output logic [N+M-1:0]    retired,
    output logic              no_spare_alarm
);
    localparam int unsigned T = N + M;

    logic [IW-1:0] map_q [N];
    logic [IW-1:0] map_d [N];
    logic [SW-1:0] used_q, used_d;
    logic [T-1:0]  ret_q, ret_d;
    logic          alarm_q;

    // Next-state selection: replace dissenting slots in order while spares last.
    always_comb begin
        map_d  = map_q;
        used_d = used_q;
        ret_d  = ret_q;
        if (!uncorrectable) begin
            for (int s = 0; s < N; s++) begin
                if (disagree[s] && (used_d < SW'(M))) begin
                    ret_d[map_q[s]] = 1'b1;
                    map_d[s]        = IW'(N) + IW'(used_d);
                    used_d          = used_d + SW'(1);
                end
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < N; s++) begin
                map_q[s] <= IW'(s);
            end
            used_q  <= '0;
            ret_q   <= '0;
            alarm_q <= 1'b0;
        end else begin
            map_q   <= map_d;
            used_q  <= used_d;
            ret_q   <= ret_d;
            alarm_q <= alarm_q | ((|disagree) && (used_q == SW'(M)));
        end
    end

    for (genvar s = 0; s < N; s++) begin : g_out
        assign slot_map[s*IW +: IW] = map_q[s];
    end
    assign spares_left    = SW'(M) - used_q;
    assign retired        = ret_q;
    assign no_spare_alarm = alarm_q;

    AST_SPARE_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ret_q) + int'(spares_left)) == int'(M)); // R8
    AST_SPARE_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (spares_left <= $past(spares_left))); // R8
    AST_RETIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((ret_q & $past(ret_q)) == $past(ret_q))); // R7
    AST_NO_SWAP_UNCORR: assert property (@(posedge clk) disable iff (!rst_n)
        uncorrectable |=> $stable(slot_map)); // R5
    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_q |=> alarm_q); // R6
    AST_EXHAUSTED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (spares_left == '0) |=> $stable(slot_map)); // R6
endmodule

// File: rtl/nmr_reconfig_ctrl.sv
// Module nmr_reconfig_ctrl
// Top level. Routes the active modules' words into the voting slots, votes,
// detects dissent and reconfigures through the switch. Assumes N odd and
// M >= 1. The replicated modules themselves live outside this block.
module nmr_reconfig_ctrl #(
    parameter int unsigned N_ACT = 3,
    parameter int unsigned N_SPR = 2,
    parameter int unsigned W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [(N_ACT+N_SPR)*W-1:0]   mod_words,
    output logic [W-1:0]                 voted,
    output logic [N_ACT+N_SPR-1:0]       active_mask,
    output logic [$clog2(N_SPR+1)-1:0]   spares_left,
    output logic [N_ACT+N_SPR-1:0]       retired,
    output logic                         no_spare_alarm,
    output logic                         uncorrectable
);
    localparam int unsigned T  = N_ACT + N_SPR;
    localparam int unsigned IW = $clog2(T);
    localparam int unsigned SW = $clog2(N_SPR + 1);

    logic [W-1:0]        mod_arr [T];
    logic [N_ACT*IW-1:0] slot_map;
    logic [N_ACT*W-1:0]  slot_words;
    logic [N_ACT-1:0]    disagree;

    // Unpack the flat module bus.
    for (genvar i = 0; i < T; i++) begin : g_unpack
        assign mod_arr[i] = mod_words[i*W +: W];
    end

    // Slot multiplexers: each voting slot reads the module it is mapped to.
    for (genvar s = 0; s < N_ACT; s++) begin : g_slot
        assign slot_words[s*W +: W] = mod_arr[slot_map[s*IW +: IW]];
    end

    // Decode the slot table into a per-module active mask.
    always_comb begin
        active_mask = '0;
        for (int s = 0; s < N_ACT; s++) begin
            active_mask[slot_map[s*IW +: IW]] = 1'b1;
        end
    end

    nmr_voter #(.N(N_ACT), .W(W)) voter_i (
        .slot_words (slot_words),
        .voted      (voted)
    );

    nmr_disagree #(.N(N_ACT), .W(W)) detect_i (
        .slot_words    (slot_words),
        .voted         (voted),
        .disagree      (disagree),
        .uncorrectable (uncorrectable)
    );

    nmr_switch #(.N(N_ACT), .M(N_SPR), .IW(IW), .SW(SW)) switch_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .disagree       (disagree),
        .uncorrectable  (uncorrectable),
        .slot_map       (slot_map),
        .spares_left    (spares_left),
        .retired        (retired),
        .no_spare_alarm (no_spare_alarm)
    );

    AST_ACTIVE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(active_mask) == int'(N_ACT)); // R4
    AST_RETIRED_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (retired & active_mask) == '0); // R7
    AST_UNCORR_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        uncorrectable |=> $stable(retired)); // R5
endmodule

// File: tb/nmr_reconfig_ctrl_tb.sv
// Directed bench for nmr_reconfig_ctrl with N=3 actives, 2 spares, 8-bit words.
module nmr_reconfig_ctrl_tb_top;
    localparam int N = 3;
    localparam int M = 2;
    localparam int W = 8;
    localparam int T = N + M;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [T*W-1:0] mod_words = '0;
    logic [W-1:0]   voted;
    logic [T-1:0]   active_mask;
    logic [1:0]     spares_left;
    logic [T-1:0]   retired;
    logic           no_spare_alarm;
    logic           uncorrectable;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk; // 50 MHz

    nmr_reconfig_ctrl #(.N_ACT(N), .N_SPR(M), .W(W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .mod_words      (mod_words),
        .voted          (voted),
        .active_mask    (active_mask),
        .spares_left    (spares_left),
        .retired        (retired),
        .no_spare_alarm (no_spare_alarm),
        .uncorrectable  (uncorrectable)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_mod(input int i, input logic [W-1:0] v);
        mod_words[i*W +: W] = v;
    endtask

    task automatic set_all(input logic [W-1:0] v);
        for (int i = 0; i < T; i++) mod_words[i*W +: W] = v;
    endtask

    // Reset with all modules agreeing on base; returns at a falling edge.
    task automatic do_reset(input logic [W-1:0] base);
        @(negedge clk);
        rst_n = 1'b0;
        set_all(base);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state;
        do_reset(8'hA5);
        #1;
        chk("R3 active_mask", 32'(active_mask), 32'h07);
        chk("R3 spares_left", 32'(spares_left), 32'd2);
        chk("R3 retired", 32'(retired), 32'h00);
        chk("R3 alarm", 32'(no_spare_alarm), 32'd0);
        chk("R1 agreeing vote", 32'(voted), 32'hA5);
        chk("R5 no uncorrectable", 32'(uncorrectable), 32'd0);
    endtask

    task automatic t_majority_patterns;
        do_reset(8'h00);
        // Three different words: majority is AB+BC+AC = E8, all dissent.
        @(negedge clk);
        set_mod(0, 8'hF0); set_mod(1, 8'hCC); set_mod(2, 8'hAA);
        #1;
        chk("R1 three-way vote", 32'(voted), 32'hE8);
        chk("R5 all dissent", 32'(uncorrectable), 32'd1);
        @(negedge clk);
        chk("R5 no swap", 32'(active_mask), 32'h07);
        chk("R5 spares kept", 32'(spares_left), 32'd2);
        set_mod(0, 8'hFF); set_mod(1, 8'h00); set_mod(2, 8'h0F);
        #1;
        chk("R1 second pattern", 32'(voted), 32'h0F);
        set_all(8'h5A);
        #1;
        chk("R1 agreeing 5A", 32'(voted), 32'h5A);
        chk("R5 cleared", 32'(uncorrectable), 32'd0);
    endtask

    task automatic t_first_fault;
        do_reset(8'h3C);
        @(negedge clk);
        set_mod(1, 8'hC3);
        #1;
        chk("R2 masked in detect cycle", 32'(voted), 32'h3C);
        chk("R2 mask unchanged yet", 32'(active_mask), 32'h07);
        chk("R5 single fault correctable", 32'(uncorrectable), 32'd0);
        @(negedge clk);
        chk("R4 spare 3 takes slot", 32'(active_mask), 32'h0D);
        chk("R4 module 1 retired", 32'(retired), 32'h02);
        chk("R8 one spare used", 32'(spares_left), 32'd1);
        set_mod(1, 8'hFF);
        #1;
        chk("R7 retired input ignored", 32'(voted), 32'h3C);
        @(negedge clk);
        chk("R7 stays retired", 32'(active_mask), 32'h0D);
        chk("R8 no extra spare used", 32'(spares_left), 32'd1);
    endtask

    task automatic t_exhaustion;
        do_reset(8'h96);
        @(negedge clk);
        set_mod(0, 8'h00);
        @(negedge clk);
        chk("R4 first swap", 32'(active_mask), 32'h0E);
        set_mod(2, 8'h11);
        @(negedge clk);
        chk("R4 ascending spare", 32'(active_mask), 32'h1A);
        chk("R4 retired pair", 32'(retired), 32'h05);
        chk("R8 pool empty", 32'(spares_left), 32'd0);
        chk("R6 alarm not yet", 32'(no_spare_alarm), 32'd0);
        set_mod(3, 8'h69);
        #1;
        chk("R6 still masking", 32'(voted), 32'h96);
        @(negedge clk);
        chk("R6 alarm raised", 32'(no_spare_alarm), 32'd1);
        chk("R6 set frozen", 32'(active_mask), 32'h1A);
        chk("R6 retired frozen", 32'(retired), 32'h05);
        set_mod(3, 8'h96);
        @(negedge clk);
        chk("R6 alarm sticky", 32'(no_spare_alarm), 32'd1);
        do_reset(8'h96);
        #1;
        chk("R3 alarm cleared", 32'(no_spare_alarm), 32'd0);
        chk("R3 mask restored", 32'(active_mask), 32'h07);
    endtask

    task automatic t_compensating;
        do_reset(8'h44);
        @(negedge clk);
        set_mod(0, 8'h45); set_mod(1, 8'h46);
        #1;
        chk("R1 compensating vote", 32'(voted), 32'h44);
        chk("R5 two dissenters", 32'(uncorrectable), 32'd1);
        @(negedge clk);
        chk("R5 set unchanged", 32'(active_mask), 32'h07);
        chk("R5 none retired", 32'(retired), 32'h00);
    endtask

    task automatic t_idle_spares;
        do_reset(8'h81);
        @(negedge clk);
        set_mod(3, 8'hFF); set_mod(4, 8'h00);
        #1;
        chk("R9 vote unaffected", 32'(voted), 32'h81);
        chk("R9 no flag", 32'(uncorrectable), 32'd0);
        @(negedge clk);
        chk("R9 set unchanged", 32'(active_mask), 32'h07);
        chk("R9 spares kept", 32'(spares_left), 32'd2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_state();
        t_majority_patterns();
        t_first_fault();
        t_exhaustion();
        t_compensating();
        t_idle_spares();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule